// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This unit sits beside a 16-bit DSP core and watches its buses every cycle. It sees the program-fetch address and page, the data-bus address, value and direction, and a set of event strobes. The strobes cover taken branches, interrupt entry, block-repeat loop returns, trace-buffer full, illegal conditions, external register reads and writes, software traps and external abort events. When an enabled condition matches, the unit emits a one-cycle break request to the core's debug logic. It also latches the reason into a sticky cause register.

Three program-address breakpoints compare an 18-bit fetch address plus a 4-bit page. Each has a pass counter, so the first N matches are let through. One data breakpoint compares a masked address and, separately, a reference value. Each of the two comparisons is qualified by transfer direction. A coincidence mode fires only when the address and the value match in the same transfer. A 16-bit word-addressed register port, with a window at word offsets 0x60 to 0x6F, gives access to every setting, counter and flag. Registers sit at odd as well as even offsets.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: After a synchronous active-low reset, every register in the window reads 0 (except the live mode bits of R12), and `brk_req` is 0.
- R2: Register port offsets are as follows. 0x60 is reserved and reads 0. 0x61 holds the data-value reference. 0x62/0x64/0x66 hold the low address words of program breakpoints 1/2/3. 0x63/0x65/0x67 hold the high words: address bits 17:16 in bits 1:0 and the page in bits 7:4, with the other bits reading 0. 0x68/0x69/0x6A hold the pass counters. 0x6B holds the data mask, 0x6C the data address, 0x6D the enables, 0x6E the mode word and 0x6F the status. A write outside the window has no effect, and a read outside it returns 0.
- R3: Enable bits of 0x6D: 0 value-on-write, 1 value-on-read, 2 address-on-write, 3 address-on-read, 4 coincidence, 5 ext-reg write, 6 ext-reg read, 7/8/9 program breakpoints 1/2/3, 10 branch, 11 interrupt, 12 trace full, 13 loop return, 14 illegal, 15 single step.
- R4: A data transfer matches the address when every bit not set in the mask equals the reference address. It counts only when the enable for its direction (write when `da_write`=1) is set.
- R5: A data transfer matches the value when `da_value` equals the reference at 0x61. It counts only when the enable for its direction is set.
- R6: The coincidence cause fires, in either direction, only when the address and the value match in the same transfer and bit 4 is set.
- R7: A fetch matches a program breakpoint only when its address and page are equal and the breakpoint is enabled. A match with a non-zero counter decrements the counter and raises no break. A match with the counter at zero breaks, so a loaded count N lets N matches pass. A disabled breakpoint never changes its counter.
- R8: Event causes are gated by their enables. Branch or loop return set the branch flag, and an external register read or write sets the user-register flag. Software trap and external abort are always enabled.
- R9: Status bits of 0x6F: 0 value, 1 address, 2 coincidence, 3 user-register, 4 external abort, 5/6/7 program breakpoints 1/2/3, 11 branch, 12 interrupt, 13 trace full, 14 illegal, 15 software trap. The flags are sticky, and writing 1 to a bit clears it. A cause arriving in the same cycle as the clear wins.
- R10: `brk_req` rises one clock after the first cycle in which any enabled cause is present, and lasts one cycle. It stays low while causes persist over consecutive cycles.
- R11: With single step enabled, every valid fetch raises a break without setting any status flag.
- R12: Bits of 0x6E: bit 15 shows `in_debug`, bit 14 shows `in_boot`, and bit 13 is a sticky flag. The flag is set when `usr_reset` pulses while `in_debug` is 1, and writing 1 to bit 13 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| pf_valid | input | 1 | Program fetch valid |
| pf_addr | input | 18 | Program fetch address |
| pf_page | input | 4 | Program fetch page |
| da_valid | input | 1 | Data transfer valid |
| da_write | input | 1 | Data transfer is a write |
| da_addr | input | 16 | Data address |
| da_value | input | 16 | Data value |
| ev_branch | input | 1 | Branch taken |
| ev_loop | input | 1 | Return to the start of a repeat loop |
| ev_irq | input | 1 | Interrupt service entry |
| ev_tbfull | input | 1 | Trace buffer full |
| ev_illegal | input | 1 | Illegal condition |
| ev_xrd | input | 1 | External register read |
| ev_xwr | input | 1 | External register write |
| ev_swtrap | input | 1 | Software trap |
| ev_abort | input | 1 | External abort event |
| in_debug | input | 1 | Core is in debug mode |
| in_boot | input | 1 | Core is in boot mode |
| usr_reset | input | 1 | User reset strobe |
| brk_req | output | 1 | Break request pulse |

## Verification
The hardest state to reach is the pass-counter boundary. Here a breakpoint has to see repeated matching fetches, with the counter read back between them, until it reaches zero, and only the next match may break. The stimulus loads a count of two, issues three identical fetches separated by idle cycles, and checks the break output and the counter value after each one. It then repeats a fetch with the breakpoint disabled to show that the counter holds. A second delicate case is a cause and its clear landing in one cycle, reached by driving an abort strobe during the status write.

// File: rtl/dbgbp_pkg.sv
// Package: shared sizes, register offsets and bit positions of the
// debug breakpoint match unit. Assumes a 16-entry register window.
package dbgbp_pkg;
    localparam int DW       = 16;  // register and data width
    localparam int PA_HI_W  = 2;   // program address bits above DW
    localparam int PG_W     = 4;   // program page width
    localparam int PG_LSB   = 4;   // page field position in high word
    localparam int CNT_W    = 16;  // pass counter width
    localparam int N_PBP    = 3;   // number of program breakpoints

    // word offsets inside the window
    localparam logic [3:0] OFS_RSVD   = 4'h0;
    localparam logic [3:0] OFS_VREF   = 4'h1;
    localparam logic [3:0] OFS_PB0    = 4'h2;
    localparam logic [3:0] OFS_CNT0   = 4'h8;
    localparam logic [3:0] OFS_AMASK  = 4'hB;
    localparam logic [3:0] OFS_AREF   = 4'hC;
    localparam logic [3:0] OFS_ENA    = 4'hD;
    localparam logic [3:0] OFS_MODE   = 4'hE;
    localparam logic [3:0] OFS_STAT   = 4'hF;

    // enable bits
    localparam int EN_VW   = 0;
    localparam int EN_VR   = 1;
    localparam int EN_AW   = 2;
    localparam int EN_AR   = 3;
    localparam int EN_CD   = 4;
    localparam int EN_XW   = 5;
    localparam int EN_XR   = 6;
    localparam int EN_PB0  = 7;
    localparam int EN_BRA  = 10;
    localparam int EN_IRQ  = 11;
    localparam int EN_TBF  = 12;
    localparam int EN_LOOP = 13;
    localparam int EN_ILL  = 14;
    localparam int EN_STEP = 15;

    // status bits
    localparam int ST_VAL  = 0;
    localparam int ST_ADR  = 1;
    localparam int ST_CD   = 2;
    localparam int ST_XREG = 3;
    localparam int ST_ABT  = 4;
    localparam int ST_PB0  = 5;
    localparam int ST_BRA  = 11;
    localparam int ST_IRQ  = 12;
    localparam int ST_TBF  = 13;
    localparam int ST_ILL  = 14;
    localparam int ST_TRAP = 15;

    // mode word bits
    localparam int MD_DBG  = 15;
    localparam int MD_BOOT = 14;
    localparam int MD_ERR  = 13;
endpackage

// File: rtl/dbgbp_data_cmp.sv
// Module: dbgbp_data_cmp
// Combinational data-bus comparator. Produces the value, address and
// coincidence causes for one transfer. Assumes a set mask bit means
// "ignore this address bit" and that enables are already decoded.
module dbgbp_data_cmp #(
    parameter int DW = 16
) (
    input  logic          da_valid,
    input  logic          da_write,
    input  logic [DW-1:0] da_addr,
    input  logic [DW-1:0] da_value,
    input  logic [DW-1:0] ref_addr,
    input  logic [DW-1:0] addr_mask,
    input  logic [DW-1:0] ref_value,
    input  logic          en_vw,
    input  logic          en_vr,
    input  logic          en_aw,
    input  logic          en_ar,
    input  logic          en_cd,
    output logic          val_hit,
    output logic          adr_hit,
    output logic          cd_hit
);
    logic adr_eq;
    logic val_eq;
    logic dir_val_en;
    logic dir_adr_en;

    // raw comparisons, independent of direction
    always_comb begin
        adr_eq = ((da_addr ^ ref_addr) & ~addr_mask) == '0;
        val_eq = (da_value == ref_value);
    end

    // pick the enable matching the transfer direction
    always_comb begin
        dir_val_en = da_write ? en_vw : en_vr;
        dir_adr_en = da_write ? en_aw : en_ar;
    end

    // qualified causes
    always_comb begin
        val_hit = da_valid && val_eq && dir_val_en;
        adr_hit = da_valid && adr_eq && dir_adr_en;
        cd_hit  = da_valid && adr_eq && val_eq && en_cd;
    end
endmodule

// File: rtl/dbgbp_prog_bp.sv
// Module: dbgbp_prog_bp
// One program-address breakpoint: low/high address and page registers,
// a pass counter and the match logic. Assumes register writes and
// counter decrements never coincide with intent (a write wins).
module dbgbp_prog_bp #(
    parameter int DW      = 16,
    parameter int HI_W    = 2,
    parameter int PG_W    = 4,
    parameter int PG_LSB  = 4,
    parameter int CNT_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 wr_lo,
    input  logic                 wr_hi,
    input  logic                 wr_cnt,
    input  logic [DW-1:0]        wdata,
    input  logic                 pf_valid,
    input  logic [DW+HI_W-1:0]   pf_addr,
    input  logic [PG_W-1:0]      pf_page,
    output logic [DW-1:0]        lo_word,
    output logic [DW-1:0]        hi_word,
    output logic [CNT_W-1:0]     cnt_q,
    output logic                 hit
);
    localparam int PA_W = DW + HI_W;

    logic [DW-1:0]   lo_q;
    logic [HI_W-1:0] hi_q;
    logic [PG_W-1:0] pg_q;
    logic            armed;

    // address and page registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
            pg_q <= '0;
        end else begin
            if (wr_lo) lo_q <= wdata;
            if (wr_hi) begin
                hi_q <= wdata[HI_W-1:0];
                pg_q <= wdata[PG_LSB +: PG_W];
            end
        end
    end

    // enabled fetch match on full address plus page
    always_comb begin
        armed = enable && pf_valid
                && (pf_addr == PA_W'({hi_q, lo_q}))
                && (pf_page == pg_q);
        hit   = armed && (cnt_q == '0);
    end

    // pass counter: load from port, otherwise count down on a match
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_cnt) begin
            cnt_q <= wdata[CNT_W-1:0];
        end else if (armed && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // register read-back views
    always_comb begin
        lo_word = lo_q;
        hi_word = '0;
        hi_word[HI_W-1:0] = hi_q;
        hi_word[PG_LSB +: PG_W] = pg_q;
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !wr_cnt) |=> $stable(cnt_q)) else $error("counter moved while disabled"); // R7
    AST_PASS_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !wr_cnt) |=> (cnt_q == '0)) else $error("counter left zero after a break"); // R7
endmodule

// File: rtl/dbg_bkpt_unit.sv
// Module: dbg_bkpt_unit
// Top of the debug breakpoint match unit: register window, enable
// gating, sticky cause flags, mode word and the break pulse. Assumes a
// single-cycle register write strobe and combinational register reads.
module dbg_bkpt_unit
    import dbgbp_pkg::*;
#(
    parameter int          RADDR_W  = 8,
    parameter logic [7:0]  WIN_BASE = 8'h60
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [RADDR_W-1:0]     reg_addr,
    input  logic [DW-1:0]          reg_wdata,
    output logic [DW-1:0]          reg_rdata,
    input  logic                   pf_valid,
    input  logic [DW+PA_HI_W-1:0]  pf_addr,
    input  logic [PG_W-1:0]        pf_page,
    input  logic                   da_valid,
    input  logic                   da_write,
    input  logic [DW-1:0]          da_addr,
    input  logic [DW-1:0]          da_value,
    input  logic                   ev_branch,
    input  logic                   ev_loop,
    input  logic                   ev_irq,
    input  logic                   ev_tbfull,
    input  logic                   ev_illegal,
    input  logic                   ev_xrd,
    input  logic                   ev_xwr,
    input  logic                   ev_swtrap,
    input  logic                   ev_abort,
    input  logic                   in_debug,
    input  logic                   in_boot,
    input  logic                   usr_reset,
    output logic                   brk_req
);
    logic [3:0]      ofs;
    logic            in_win;
    logic            wr_en;

    logic [DW-1:0]   vref_q;
    logic [DW-1:0]   amask_q;
    logic [DW-1:0]   aref_q;
    logic [DW-1:0]   ena_q;
    logic [DW-1:0]   stat_q;
    logic            err_q;
    logic            hit_q;

    logic [DW-1:0]   pb_lo  [N_PBP];
    logic [DW-1:0]   pb_hi  [N_PBP];
    logic [CNT_W-1:0] pb_cnt [N_PBP];
    logic [N_PBP-1:0] pb_hit;

    logic            val_hit;
    logic            adr_hit;
    logic            cd_hit;
    logic [DW-1:0]   cause;
    logic            hit_any;
    logic            stat_wr;

    // window decode
    always_comb begin
        ofs    = reg_addr[3:0];
        in_win = (reg_addr[RADDR_W-1:4] == WIN_BASE[RADDR_W-1:4]);
        wr_en  = reg_we && in_win;
        stat_wr = wr_en && (ofs == OFS_STAT);
    end

    // plain configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vref_q  <= '0;
            amask_q <= '0;
            aref_q  <= '0;
            ena_q   <= '0;
        end else if (wr_en) begin
            if (ofs == OFS_VREF)  vref_q  <= reg_wdata;
            if (ofs == OFS_AMASK) amask_q <= reg_wdata;
            if (ofs == OFS_AREF)  aref_q  <= reg_wdata;
            if (ofs == OFS_ENA)   ena_q   <= reg_wdata;
        end
    end

    // program breakpoints, one instance each
    for (genvar g = 0; g < N_PBP; g++) begin : g_pbp
        localparam logic [3:0] LO_OFS  = 4'(OFS_PB0 + 2 * g);
        localparam logic [3:0] HI_OFS  = 4'(OFS_PB0 + 2 * g + 1);
        localparam logic [3:0] CNT_OFS = 4'(OFS_CNT0 + g);

        dbgbp_prog_bp #(
            .DW     (DW),
            .HI_W   (PA_HI_W),
            .PG_W   (PG_W),
            .PG_LSB (PG_LSB),
            .CNT_W  (CNT_W)
        ) i_pbp (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable   (ena_q[EN_PB0 + g]),
            .wr_lo    (wr_en && (ofs == LO_OFS)),
            .wr_hi    (wr_en && (ofs == HI_OFS)),
            .wr_cnt   (wr_en && (ofs == CNT_OFS)),
            .wdata    (reg_wdata),
            .pf_valid (pf_valid),
            .pf_addr  (pf_addr),
            .pf_page  (pf_page),
            .lo_word  (pb_lo[g]),
            .hi_word  (pb_hi[g]),
            .cnt_q    (pb_cnt[g]),
            .hit      (pb_hit[g])
        );
    end

    dbgbp_data_cmp #(.DW(DW)) i_dcmp (
        .da_valid  (da_valid),
        .da_write  (da_write),
        .da_addr   (da_addr),
        .da_value  (da_value),
        .ref_addr  (aref_q),
        .addr_mask (amask_q),
        .ref_value (vref_q),
        .en_vw     (ena_q[EN_VW]),
        .en_vr     (ena_q[EN_VR]),
        .en_aw     (ena_q[EN_AW]),
        .en_ar     (ena_q[EN_AR]),
        .en_cd     (ena_q[EN_CD]),
        .val_hit   (val_hit),
        .adr_hit   (adr_hit),
        .cd_hit    (cd_hit)
    );

    // gate events with their enables and gather the cause vector
    always_comb begin
        cause = '0;
        cause[ST_VAL]  = val_hit;
        cause[ST_ADR]  = adr_hit;
        cause[ST_CD]   = cd_hit;
        cause[ST_XREG] = (ev_xwr && ena_q[EN_XW]) || (ev_xrd && ena_q[EN_XR]);
        cause[ST_ABT]  = ev_abort;
        cause[ST_PB0 +: N_PBP] = pb_hit;
        cause[ST_BRA]  = (ev_branch && ena_q[EN_BRA]) || (ev_loop && ena_q[EN_LOOP]);
        cause[ST_IRQ]  = ev_irq && ena_q[EN_IRQ];
        cause[ST_TBF]  = ev_tbfull && ena_q[EN_TBF];
        cause[ST_ILL]  = ev_illegal && ena_q[EN_ILL];
        cause[ST_TRAP] = ev_swtrap;
        hit_any = (|cause) || (pf_valid && ena_q[EN_STEP]);
    end

    // sticky status: write-one-to-clear, new causes win
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~(stat_wr ? reg_wdata : '0)) | cause;
        end
    end

    // sticky user-reset-in-debug flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (usr_reset && in_debug) begin
            err_q <= 1'b1;
        end else if (wr_en && (ofs == OFS_MODE) && reg_wdata[MD_ERR]) begin
            err_q <= 1'b0;
        end
    end

    // break pulse on the first cycle of a match run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q   <= 1'b0;
            brk_req <= 1'b0;
        end else begin
            hit_q   <= hit_any;
            brk_req <= hit_any && !hit_q;
        end
    end

    // register read multiplexer
    always_comb begin
        reg_rdata = '0;
        if (in_win) begin
            case (ofs)
                OFS_VREF:  reg_rdata = vref_q;
                OFS_AMASK: reg_rdata = amask_q;
                OFS_AREF:  reg_rdata = aref_q;
                OFS_ENA:   reg_rdata = ena_q;
                OFS_STAT:  reg_rdata = stat_q;
                OFS_MODE: begin
                    reg_rdata[MD_DBG]  = in_debug;
                    reg_rdata[MD_BOOT] = in_boot;
                    reg_rdata[MD_ERR]  = err_q;
                end
                default: begin
                    for (int k = 0; k < N_PBP; k++) begin
                        if (ofs == 4'(OFS_PB0 + 2 * k))     reg_rdata = pb_lo[k];
                        if (ofs == 4'(OFS_PB0 + 2 * k + 1)) reg_rdata = pb_hi[k];
                        if (ofs == 4'(OFS_CNT0 + k))        reg_rdata[CNT_W-1:0] = pb_cnt[k];
                    end
                end
            endcase
        end
    end

    AST_BRK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |=> !brk_req) else $error("break pulse longer than one cycle"); // R10
    AST_BRK_FROM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_req) |-> ($past(stat_wr) || (stat_q != '0) || $past(pf_valid)))
        else $error("break without any cause"); // R10
    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q)))
        else $error("status flag dropped without a clear"); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !wr_en) |=> err_q) else $error("mode error flag dropped"); // R12
endmodule

// File: tb/test_dbg_bkpt_unit.sv
// Bench for dbg_bkpt_unit: a vector table for the data comparator,
// then directed tests for reset, window, counters, events and pulses.
module test_dbg_bkpt_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        pf_valid = 1'b0;
    logic [17:0] pf_addr = '0;
    logic [3:0]  pf_page = '0;
    logic        da_valid = 1'b0, da_write = 1'b0;
    logic [15:0] da_addr = '0, da_value = '0;
    logic        ev_branch = 0, ev_loop = 0, ev_irq = 0, ev_tbfull = 0, ev_illegal = 0;
    logic        ev_xrd = 0, ev_xwr = 0, ev_swtrap = 0, ev_abort = 0;
    logic        in_debug = 0, in_boot = 0, usr_reset = 0;
    logic        brk_req;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] rv;

    always #4 clk = ~clk;

    dbg_bkpt_unit i_dbg_bkpt_unit (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pf_valid(pf_valid),
        .pf_addr(pf_addr), .pf_page(pf_page), .da_valid(da_valid),
        .da_write(da_write), .da_addr(da_addr), .da_value(da_value),
        .ev_branch(ev_branch), .ev_loop(ev_loop), .ev_irq(ev_irq),
        .ev_tbfull(ev_tbfull), .ev_illegal(ev_illegal), .ev_xrd(ev_xrd),
        .ev_xwr(ev_xwr), .ev_swtrap(ev_swtrap), .ev_abort(ev_abort),
        .in_debug(in_debug), .in_boot(in_boot), .usr_reset(usr_reset),
        .brk_req(brk_req)
    );

    // data vectors: {enables, write, addr, value, expected status, expected break}
    localparam logic [65:0] DVEC [9] = '{
        {16'h0004, 1'b1, 16'h1235, 16'h0000, 16'h0002, 1'b1},
        {16'h0004, 1'b0, 16'h1235, 16'h0000, 16'h0000, 1'b0},
        {16'h0008, 1'b0, 16'h123F, 16'h0000, 16'h0002, 1'b1},
        {16'h0008, 1'b0, 16'h1245, 16'h0000, 16'h0000, 1'b0},
        {16'h0001, 1'b1, 16'h0000, 16'hBEEF, 16'h0001, 1'b1},
        {16'h0002, 1'b1, 16'h0000, 16'hBEEF, 16'h0000, 1'b0},
        {16'h0010, 1'b0, 16'h1231, 16'hBEEF, 16'h0004, 1'b1},
        {16'h0010, 1'b0, 16'h1231, 16'hBEEE, 16'h0000, 1'b0},
        {16'h001F, 1'b1, 16'h1232, 16'hBEEF, 16'h0007, 1'b1}
    };

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_ev(input int idx, input logic v);
        case (idx)
            0: ev_branch  = v;
            1: ev_loop    = v;
            2: ev_irq     = v;
            3: ev_tbfull  = v;
            4: ev_illegal = v;
            5: ev_xwr     = v;
            6: ev_xrd     = v;
            7: ev_swtrap  = v;
            default: ev_abort = v;
        endcase
    endtask

    // one gated event: enable, fire, check break and flag
    task automatic ev_case(input int idx, input logic [15:0] ena, input logic [15:0] exp);
        logic [15:0] s;
        wr(8'h6D, ena);
        wr(8'h6F, 16'hFFFF);
        set_ev(idx, 1'b1);
        tick();
        chk("R8 event break", {15'd0, brk_req}, {15'd0, exp != 16'h0});
        set_ev(idx, 1'b0);
        rd(8'h6F, s);
        chk("R8 event status", s, exp);
        tick();
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 brk_req", {15'd0, brk_req}, 16'h0);
        rd(8'h6D, rv); chk("R1 enables", rv, 16'h0);
        rd(8'h6F, rv); chk("R1 status", rv, 16'h0);
        rd(8'h68, rv); chk("R1 counter", rv, 16'h0);

        // R2 window layout and out-of-window access
        wr(8'h63, 16'hFFFF);
        rd(8'h63, rv); chk("R2 high word fields", rv, 16'h00F3);
        wr(8'h63, 16'h0000);
        wr(8'h70, 16'hAAAA);
        rd(8'h70, rv); chk("R2 outside window", rv, 16'h0);
        rd(8'h60, rv); chk("R2 reserved", rv, 16'h0);
        wr(8'h69, 16'h1234);
        rd(8'h69, rv); chk("R2 counter 2", rv, 16'h1234);
        wr(8'h69, 16'h0000);

        // R12 mode word
        in_debug = 1'b1; in_boot = 1'b1;
        rd(8'h6E, rv); chk("R12 mode bits", rv, 16'hC000);
        usr_reset = 1'b1; tick(); usr_reset = 1'b0;
        rd(8'h6E, rv); chk("R12 error set", rv, 16'hE000);
        wr(8'h6E, 16'h2000);
        rd(8'h6E, rv); chk("R12 error cleared", rv, 16'hC000);
        in_debug = 1'b0; in_boot = 1'b0;

        // R3 R4 R5 R6 data vector table
        wr(8'h6C, 16'h1230);
        wr(8'h6B, 16'h000F);
        wr(8'h61, 16'hBEEF);
        for (int i = 0; i < 9; i++) begin
            wr(8'h6D, DVEC[i][65:50]);
            wr(8'h6F, 16'hFFFF);
            da_write = DVEC[i][49];
            da_addr  = DVEC[i][48:33];
            da_value = DVEC[i][32:17];
            da_valid = 1'b1;
            tick();
            chk("R4 R5 R6 data break", {15'd0, brk_req}, {15'd0, DVEC[i][0]});
            da_valid = 1'b0;
            rd(8'h6F, rv); chk("R3 R4 R5 R6 data status", rv, DVEC[i][16:1]);
            tick();
        end

        // R7 pass counter on breakpoint 1
        wr(8'h62, 16'h4567);
        wr(8'h63, 16'h0051);
        wr(8'h68, 16'd2);
        wr(8'h6D, 16'h0080);
        wr(8'h6F, 16'hFFFF);
        pf_addr = 18'h14567; pf_page = 4'd5;
        for (int n = 0; n < 3; n++) begin
            pf_valid = 1'b1;
            tick();
            pf_valid = 1'b0;
            chk("R7 pass break", {15'd0, brk_req}, {15'd0, n == 2});
            rd(8'h68, rv); chk("R7 counter", rv, (n == 0) ? 16'd1 : 16'd0);
            tick();
        end
        rd(8'h6F, rv); chk("R7 status bp1", rv, 16'h0020);
        wr(8'h6F, 16'hFFFF);
        pf_page = 4'd6; pf_valid = 1'b1; tick(); pf_valid = 1'b0;
        chk("R7 page mismatch", {15'd0, brk_req}, 16'h0);
        tick();
        // disabled breakpoint keeps its counter
        wr(8'h68, 16'd1);
        wr(8'h6D, 16'h0200);
        pf_page = 4'd5; pf_valid = 1'b1; tick(); pf_valid = 1'b0;
        chk("R7 disabled no break", {15'd0, brk_req}, 16'h0);
        rd(8'h68, rv); chk("R7 disabled counter", rv, 16'd1);
        tick();
        // breakpoint 3 with zero count
        wr(8'h66, 16'h0100);
        wr(8'h6F, 16'hFFFF);
        pf_addr = 18'h00100; pf_page = 4'd0; pf_valid = 1'b1; tick(); pf_valid = 1'b0;
        chk("R7 bp3 break", {15'd0, brk_req}, 16'h1);
        rd(8'h6F, rv); chk("R7 bp3 status", rv, 16'h0080);
        tick();

        // R8 event gating
        ev_case(0, 16'h0400, 16'h0800);
        ev_case(1, 16'h2000, 16'h0800);
        ev_case(2, 16'h0800, 16'h1000);
        ev_case(3, 16'h1000, 16'h2000);
        ev_case(4, 16'h4000, 16'h4000);
        ev_case(5, 16'h0020, 16'h0008);
        ev_case(6, 16'h0040, 16'h0008);
        ev_case(7, 16'h0000, 16'h8000);
        ev_case(8, 16'h0000, 16'h0010);
        ev_case(0, 16'h2000, 16'h0000);
        ev_case(6, 16'h0020, 16'h0000);

        // R10 pulse over a persistent cause
        wr(8'h6D, 16'h0400);
        ev_branch = 1'b1;
        tick(); chk("R10 first pulse", {15'd0, brk_req}, 16'h1);
        tick(); chk("R10 held low 1", {15'd0, brk_req}, 16'h0);
        tick(); chk("R10 held low 2", {15'd0, brk_req}, 16'h0);
        ev_branch = 1'b0;
        tick(); chk("R10 idle", {15'd0, brk_req}, 16'h0);
        ev_branch = 1'b1;
        tick(); chk("R10 second pulse", {15'd0, brk_req}, 16'h1);
        ev_branch = 1'b0;
        tick();

        // R9 sticky, write-one-to-clear, set wins
        wr(8'h6D, 16'h0000);
        wr(8'h6F, 16'hFFFF);
        ev_swtrap = 1'b1; tick(); ev_swtrap = 1'b0; tick();
        wr(8'h6F, 16'h0000);
        rd(8'h6F, rv); chk("R9 sticky", rv, 16'h8000);
        ev_abort = 1'b1; tick(); ev_abort = 1'b0;
        rd(8'h6F, rv); chk("R9 accumulate", rv, 16'h8010);
        wr(8'h6F, 16'h8000);
        rd(8'h6F, rv); chk("R9 partial clear", rv, 16'h0010);
        ev_abort = 1'b1;
        wr(8'h6F, 16'h0010);
        ev_abort = 1'b0;
        rd(8'h6F, rv); chk("R9 set wins", rv, 16'h0010);
        tick();
        wr(8'h6F, 16'hFFFF);

        // R11 single step
        wr(8'h6D, 16'h8000);
        pf_addr = 18'h3ABCD; pf_valid = 1'b1; tick(); pf_valid = 1'b0;
        chk("R11 step break", {15'd0, brk_req}, 16'h1);
        rd(8'h6F, rv); chk("R11 no flag", rv, 16'h0000);
        tick();
        wr(8'h6D, 16'h0000);
        pf_valid = 1'b1; tick(); pf_valid = 1'b0;
        chk("R11 step off", {15'd0, brk_req}, 16'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule